// File: doc/BRIEF.md
# Network Port Selection Controller

This block decides which of two physical network attachments is live: the attachment-unit port (AUI) or the twisted-pair port. Exactly one port is enabled at a time. A transceiver-disable output tells the external transceiver whether the AUI side is in use. The choice comes from one of three sources. A configuration bit can hand the decision to an external select pin. Failing that, an automatic mode follows the twisted-pair link status. Failing both, a software select bit decides.

The select pin has a second use. When the external address-reject option is turned on, the pin stops selecting a port and acts as a reject input instead. Its level is sampled once per frame, at the moment the destination address has been received, and it is ORed with the internal address filter's verdict. A sleep request resets the block's state and forces every output to its reset level. While sleep is asserted, all other inputs are ignored.

A port change takes effect only between frames, so a frame in flight never has its port pulled away.

Top module: `portsel_ctrl`

## Requirements
- R1: `tp_en` and `aui_en` are never high together. Outside reset and sleep, exactly one of them is high from the first clock edge onward.
- R2: When `cfg_pin_sel`=1 and `cfg_ext_rej`=0, a high on `sel_pin` selects twisted pair (`tp_en`=1) and a low selects AUI (`aui_en`=1).
- R3: When pin selection is not in force and `cfg_auto_sel`=0, `sw_sel_tp`=1 selects twisted pair and 0 selects AUI. `sel_pin` has no effect on the port.
- R4: When pin selection is not in force and `cfg_auto_sel`=1, twisted pair is selected while `link_good`=1 and AUI is selected otherwise.
- R5: Priority is pin selection first, then automatic, then software. Setting `cfg_ext_rej`=1 takes pin selection out of force even when `cfg_pin_sel`=1.
- R6: The selected port is loaded at a clock edge only if `frame_busy`=0 at that edge, or if no port is yet enabled. While `frame_busy`=1 the enabled port holds.
- R7: `xcvr_dis` is 1 when twisted pair is enabled, during reset and during sleep. It is 0 when AUI is enabled.
- R8: At a clock edge with `addr_done`=1, the block captures `int_reject` OR (`cfg_ext_rej` AND `sel_pin`) into `rej_out`. After that edge `rej_vld` is high for one cycle, and `rej_out` holds until the next capture.
- R9: With `cfg_ext_rej`=0, `sel_pin` has no effect on `rej_out`.
- R10: While `sleep_req`=1, in the same cycle, `tp_en`=0, `aui_en`=0, `xcvr_dis`=1, `rej_out`=0 and `rej_vld`=0. Inputs are ignored during sleep. At the first edge after release, a fresh port choice is loaded.
- R11: After reset, `tp_en`=0, `aui_en`=0, `xcvr_dis`=1, `rej_out`=0 and `rej_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pin_sel | input | 1 | Hand the port choice to `sel_pin` |
| cfg_auto_sel | input | 1 | Choose the port from link status |
| sw_sel_tp | input | 1 | Software choice: 1 = twisted pair |
| cfg_ext_rej | input | 1 | Use `sel_pin` as the external reject input |
| sel_pin | input | 1 | Port select, or reject input when the reject option is on |
| link_good | input | 1 | Twisted-pair link status |
| frame_busy | input | 1 | A frame is in progress |
| addr_done | input | 1 | Destination address received (one-cycle pulse) |
| int_reject | input | 1 | Internal address filter rejects the frame |
| sleep_req | input | 1 | Sleep request, active high |
| tp_en | output | 1 | Twisted-pair port enabled |
| aui_en | output | 1 | AUI port enabled |
| xcvr_dis | output | 1 | Transceiver disable |
| rej_out | output | 1 | Combined reject decision for the current frame |
| rej_vld | output | 1 | `rej_out` was updated at the previous edge |

## Verification
The port enables, `xcvr_dis`, `rej_out` and `rej_vld` come from registers. Each is due one clock edge after the inputs that produced it, or is held across that edge when `frame_busy` blocks a change. Sleep is the exception: it gates the outputs in the same cycle. The bench drives inputs just after a rising edge and compares all outputs one time unit after the following rising edge. At that point a bench model has advanced by exactly one edge using the values that were present at the edge. Directed steps hold `frame_busy` across a request to change port and toggle `sel_pin` during sleep, so that hold and ignore cases are seen at the outputs.

// File: rtl/portsel_pkg.sv
package portsel_pkg;

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_AUI  = 2'd1,
    PORT_TP   = 2'd2
  } port_e;

  // pin selection in force only when the pin is not claimed for reject
  function automatic logic pin_mode_on(input logic pin_cfg, input logic ext_rej);
    return pin_cfg & ~ext_rej;
  endfunction

  // 1 = twisted pair wanted, 0 = AUI wanted
  function automatic logic pick_tp(input logic pin_cfg, input logic auto_cfg,
                                   input logic ext_rej, input logic sw_tp,
                                   input logic pin, input logic link);
    logic r;
    if (pin_mode_on(pin_cfg, ext_rej)) r = pin;
    else if (auto_cfg)                 r = link;
    else                               r = sw_tp;
    return r;
  endfunction

  function automatic logic merge_reject(input logic int_rej, input logic ext_en,
                                        input logic pin);
    return int_rej | (ext_en & pin);
  endfunction

endpackage

// File: rtl/portsel_mode_dec.sv
module portsel_mode_dec
  import portsel_pkg::*;
(
  input  logic  cfg_pin_sel,
  input  logic  cfg_auto_sel,
  input  logic  cfg_ext_rej,
  input  logic  sw_sel_tp,
  input  logic  sel_pin,
  input  logic  link_good,
  output port_e want_port
);
  logic want_tp;
  always_comb begin
    want_tp   = pick_tp(cfg_pin_sel, cfg_auto_sel, cfg_ext_rej, sw_sel_tp, sel_pin, link_good);
    want_port = want_tp ? PORT_TP : PORT_AUI;
  end
endmodule

// File: rtl/portsel_port_reg.sv
module portsel_port_reg
  import portsel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sleep_req,
  input  logic  frame_busy,
  input  port_e want_port,
  output port_e port_q,
  output logic  port_load
);
  always_comb port_load = (port_q == PORT_NONE) || !frame_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          port_q <= PORT_NONE;
    else if (sleep_req)  port_q <= PORT_NONE;
    else if (port_load)  port_q <= want_port;
  end
endmodule

// File: rtl/portsel_reject.sv
module portsel_reject
  import portsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic addr_done,
  input  logic int_reject,
  input  logic cfg_ext_rej,
  input  logic sel_pin,
  output logic rej_q,
  output logic vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_q <= 1'b0;
      vld_q <= 1'b0;
    end else if (sleep_req) begin
      rej_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= addr_done;
      if (addr_done) rej_q <= merge_reject(int_reject, cfg_ext_rej, sel_pin);
    end
  end
endmodule

// File: rtl/portsel_ctrl.sv
module portsel_ctrl
  import portsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pin_sel,
  input  logic cfg_auto_sel,
  input  logic sw_sel_tp,
  input  logic cfg_ext_rej,
  input  logic sel_pin,
  input  logic link_good,
  input  logic frame_busy,
  input  logic addr_done,
  input  logic int_reject,
  input  logic sleep_req,
  output logic tp_en,
  output logic aui_en,
  output logic xcvr_dis,
  output logic rej_out,
  output logic rej_vld
);
  port_e want_port;
  port_e port_q;
  logic  port_load;
  logic  rej_q, vld_q;

  portsel_mode_dec u_dec (
    .cfg_pin_sel (cfg_pin_sel),
    .cfg_auto_sel(cfg_auto_sel),
    .cfg_ext_rej (cfg_ext_rej),
    .sw_sel_tp   (sw_sel_tp),
    .sel_pin     (sel_pin),
    .link_good   (link_good),
    .want_port   (want_port)
  );

  portsel_port_reg u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .frame_busy(frame_busy),
    .want_port (want_port),
    .port_q    (port_q),
    .port_load (port_load)
  );

  portsel_reject u_rej (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .addr_done  (addr_done),
    .int_reject (int_reject),
    .cfg_ext_rej(cfg_ext_rej),
    .sel_pin    (sel_pin),
    .rej_q      (rej_q),
    .vld_q      (vld_q)
  );

  logic awake;
  always_comb begin
    awake    = !sleep_req;
    tp_en    = awake && (port_q == PORT_TP);
    aui_en   = awake && (port_q == PORT_AUI);
    xcvr_dis = !aui_en;
    rej_out  = awake && rej_q;
    rej_vld  = awake && vld_q;
  end

  logic unused_load;
  assign unused_load = port_load;
endmodule

// File: rtl/portsel_ctrl_chk.sv
module portsel_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_pin_sel,
  input logic cfg_auto_sel,
  input logic cfg_ext_rej,
  input logic sel_pin,
  input logic link_good,
  input logic frame_busy,
  input logic addr_done,
  input logic sleep_req,
  input logic tp_en,
  input logic aui_en,
  input logic xcvr_dis,
  input logic rej_out,
  input logic rej_vld
);
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(tp_en && aui_en)); // R1

  AST_PIN_TP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pin_sel && !cfg_ext_rej && sel_pin && !frame_busy && !sleep_req)
    |=> (sleep_req || tp_en)); // R2

  AST_PIN_AUI: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pin_sel && !cfg_ext_rej && !sel_pin && !frame_busy && !sleep_req)
    |=> (sleep_req || aui_en)); // R2

  AST_AUTO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_pin_sel && !cfg_ext_rej) && cfg_auto_sel && link_good && !frame_busy && !sleep_req)
    |=> (sleep_req || tp_en)); // R4

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && !sleep_req && (tp_en || aui_en))
    |=> (sleep_req || ($stable(tp_en) && $stable(aui_en)))); // R6

  AST_TP_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    tp_en |-> xcvr_dis); // R7

  AST_REJ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !sleep_req) |=> (sleep_req || rej_vld)); // R8

  AST_REJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_done && !sleep_req) |=> (sleep_req || ($stable(rej_out) && !rej_vld))); // R8

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (!tp_en && !aui_en && xcvr_dis && !rej_out && !rej_vld)); // R10
endmodule

bind portsel_ctrl portsel_ctrl_chk u_chk (.*);

// File: tb/portsel_ctrl_tb.sv
module portsel_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pin_sel = 0, cfg_auto_sel = 0, sw_sel_tp = 0, cfg_ext_rej = 0;
  logic sel_pin = 1, link_good = 0, frame_busy = 0, addr_done = 0;
  logic int_reject = 0, sleep_req = 0;
  logic tp_en, aui_en, xcvr_dis, rej_out, rej_vld;

  int n_chk = 0;
  int n_fail = 0;

  // bench model: 0 none, 1 AUI, 2 twisted pair
  int m_port = 0;
  bit m_rej = 0, m_vld = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  portsel_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pin_sel(cfg_pin_sel), .cfg_auto_sel(cfg_auto_sel),
    .sw_sel_tp(sw_sel_tp), .cfg_ext_rej(cfg_ext_rej), .sel_pin(sel_pin),
    .link_good(link_good), .frame_busy(frame_busy), .addr_done(addr_done),
    .int_reject(int_reject), .sleep_req(sleep_req), .tp_en(tp_en), .aui_en(aui_en),
    .xcvr_dis(xcvr_dis), .rej_out(rej_out), .rej_vld(rej_vld)
  );

  function automatic bit want_tp_ref();
    if (cfg_ext_rej == 1'b0 && cfg_pin_sel == 1'b1) return sel_pin;
    if (cfg_auto_sel) return link_good;
    return sw_sel_tp;
  endfunction

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock edge: advance the model, then compare all outputs
  task automatic step(input string req);
    bit quiet;
    if (!rst_n || sleep_req) begin
      m_port = 0; m_rej = 0; m_vld = 0;
    end else begin
      if (m_port == 0 || !frame_busy) m_port = want_tp_ref() ? 2 : 1;
      m_vld = addr_done;
      if (addr_done) m_rej = int_reject || (cfg_ext_rej && sel_pin);
    end
    @(posedge clk);
    #1;
    quiet = sleep_req || !rst_n;
    chk(tp_en,    !quiet && m_port == 2, req, "tp_en");
    chk(aui_en,   !quiet && m_port == 1, req, "aui_en");
    chk(tp_en ^ aui_en, !quiet && m_port != 0, "R1", "one port");
    chk(xcvr_dis, quiet || m_port != 1, "R7", "xcvr_dis");
    chk(rej_out,  !quiet && m_rej, "R8", "rej_out");
    chk(rej_vld,  !quiet && m_vld, "R8", "rej_vld");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005_1ce5));
    // R11: reset levels
    step("R11");
    step("R11");
    rst_n = 1'b1;
    // R2: pin selection
    cfg_pin_sel = 1; sel_pin = 1; step("R2");
    sel_pin = 0; step("R2");
    // R3: software selection, pin ignored
    cfg_pin_sel = 0; sw_sel_tp = 1; sel_pin = 1; step("R3");
    sel_pin = 0; step("R3");
    sel_pin = 1; step("R3");
    // R4: automatic from link
    cfg_auto_sel = 1; link_good = 0; step("R4");
    link_good = 1; step("R4");
    // R5: reject option removes pin mode, automatic wins
    cfg_pin_sel = 1; cfg_ext_rej = 1; sel_pin = 1; link_good = 0; step("R5");
    cfg_ext_rej = 0; step("R5");
    // R6: busy holds port, release lets it switch
    frame_busy = 1; sel_pin = 0; step("R6");
    step("R6");
    frame_busy = 0; step("R6");
    // R8: external reject through the pin
    cfg_ext_rej = 1; sel_pin = 1; int_reject = 0; addr_done = 1; step("R8");
    addr_done = 0; sel_pin = 0; step("R8");
    // R9: without the option the pin does not reject
    cfg_ext_rej = 0; sel_pin = 1; addr_done = 1; step("R9");
    addr_done = 0; int_reject = 1; step("R9");
    // R10: sleep forces reset levels and ignores inputs
    sleep_req = 1; addr_done = 1; sel_pin = 0; step("R10");
    sel_pin = 1; cfg_pin_sel = 1; step("R10");
    sleep_req = 0; addr_done = 0; step("R10");
    // random mix
    for (int i = 0; i < N_RAND; i++) begin
      cfg_pin_sel  = $urandom_range(0, 1);
      cfg_auto_sel = $urandom_range(0, 1);
      sw_sel_tp    = $urandom_range(0, 1);
      cfg_ext_rej  = ($urandom_range(0, 3) == 0);
      sel_pin      = $urandom_range(0, 1);
      link_good    = $urandom_range(0, 1);
      frame_busy   = $urandom_range(0, 1);
      addr_done    = ($urandom_range(0, 3) == 0);
      int_reject   = $urandom_range(0, 1);
      sleep_req    = ($urandom_range(0, 31) == 0);
      step("R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule